// File: doc/BRIEF.md
# Prioritized Nesting Interrupt Controller

This block arbitrates among eight interrupt levels for a small processor core. Hardware request lines pass through per-level enable bits. Software can also raise any level with a strobe and a level number. Requests are captured into a sticky pending bitmap. Capture happens only on clock cycles where the core reports that the current instruction is not an I/O access. A second bitmap records which levels are in service, so a higher level can interrupt the handler of a lower one.

The core sees one request line and a 3-bit level number, which it uses to select its vector. When the core accepts, it pulses the acknowledge input. That level then moves from pending to in-service. When a handler finishes, the core pulses the return input. This retires the highest in-service level, which lets lower pending levels through again. Both bitmaps are exposed as outputs.

Top module: `prio_irq_ctrl`

## Requirements
- R1: An active-low reset, which nothing can mask, clears both the pending and the in-service bitmaps at once. With both bitmaps clear, `irq` is 0 and `vec` is 0.
- R2: On a clock edge where `io_cycle` is 0, every bit of `hw_req & hw_en` is ORed into `pend` (bit i is level i). A level whose enable bit is 0 is not captured.
- R3: On a clock edge where `io_cycle` is 1, no new pending bit is set, whether it comes from hardware or from software.
- R4: On a clock edge where `io_cycle` is 0 and `sw_set` is 1, bit `sw_lvl` of `pend` is set.
- R5: `irq` is 1 exactly when `pend` is nonzero and its highest set index is strictly greater than the highest set index of `act`, or `act` is zero. `vec` is the highest set index of `pend`, and it is 0 when `pend` is zero. Level 7 is the most urgent.
- R6: If `ack` is 1 while `irq` is 1, the next edge clears `pend[vec]` and sets `act[vec]`. If a new capture for that same level happens on that same edge, the pending bit stays set.
- R7: If `ack` is 1 while `irq` is 0, neither bitmap changes.
- R8: `ret` clears the highest set bit of `act`. When `act` is zero, `ret` has no effect.
- R9: If `ack` and `ret` arrive on the same edge, `ret` clears the highest in-service bit from before that edge, and `ack` adds the newly accepted level.
- R10: A pending bit stays set after its request line drops, until that level is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous master reset |
| hw_req | input | 8 | Hardware request lines, one per level |
| hw_en | input | 8 | Per-level enable for hardware requests |
| sw_set | input | 1 | Software request strobe |
| sw_lvl | input | 3 | Level raised by the software strobe |
| io_cycle | input | 1 | 1 while the current instruction is an I/O access |
| ack | input | 1 | Core accepts the offered level |
| ret | input | 1 | Core leaves the current handler |
| irq | output | 1 | Interrupt request to the core |
| vec | output | 3 | Highest pending level |
| pend | output | 8 | Pending bitmap |
| act | output | 8 | In-service bitmap |

## Verification
The hardest states to reach are deep nesting combined with a simultaneous acknowledge and return. These need several levels in service at once, a higher pending level arriving, and both strobes on the same edge. The stimulus table builds this step by step. It first accepts level 2, then level 5, then level 7. Next it re-raises level 7 on the edge where that level is acknowledged. It then retires and accepts on one edge. Finally it keeps issuing returns until the in-service bitmap is empty, and issues one more.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_LVL = 8,
  localparam int LW = $clog2(N_LVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_LVL-1:0] hw_req,
  input  logic [N_LVL-1:0] hw_en,
  input  logic             sw_set,
  input  logic [LW-1:0]    sw_lvl,
  input  logic             io_cycle,
  input  logic             ack,
  input  logic             ret,
  output logic             irq,
  output logic [LW-1:0]    vec,
  output logic [N_LVL-1:0] pend,
  output logic [N_LVL-1:0] act
);

  localparam logic [N_LVL-1:0] ONE = {{(N_LVL-1){1'b0}}, 1'b1};

  function automatic logic [LW-1:0] top_idx(input logic [N_LVL-1:0] v);
    top_idx = '0;
    for (int i = 0; i < N_LVL; i++)
      if (v[i]) top_idx = LW'(i);
  endfunction

  logic [LW-1:0]    p_top, a_top;
  logic             take;
  logic [N_LVL-1:0] new_req, take_mask, ret_mask;

  assign p_top = top_idx(pend);
  assign a_top = top_idx(act);

  assign irq  = (|pend) && (~|act || p_top > a_top);
  assign vec  = p_top;
  assign take = ack & irq;

  assign new_req   = io_cycle ? '0 : ((hw_req & hw_en) | (sw_set ? (ONE << sw_lvl) : '0));
  assign take_mask = take ? (ONE << p_top) : '0;
  assign ret_mask  = (ret && |act) ? (ONE << a_top) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      act  <= '0;
    end else begin
      pend <= (pend & ~take_mask) | new_req;
      act  <= (act & ~ret_mask) | take_mask;
    end
  end

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int N_LVL = 8,
  localparam int LW = $clog2(N_LVL)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_LVL-1:0] hw_req,
  input logic [N_LVL-1:0] hw_en,
  input logic             sw_set,
  input logic [LW-1:0]    sw_lvl,
  input logic             io_cycle,
  input logic             ack,
  input logic             ret,
  input logic             irq,
  input logic [LW-1:0]    vec,
  input logic [N_LVL-1:0] pend,
  input logic [N_LVL-1:0] act
);

  a_r2_hw_captured: assert property (@(posedge clk) disable iff (!rst_n)
    !io_cycle |=> ((pend & $past(hw_req & hw_en)) == $past(hw_req & hw_en)));

  a_r3_io_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    io_cycle |=> ((pend & ~$past(pend)) == '0));

  a_r4_sw_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_cycle && sw_set) |=> pend[$past(sw_lvl)]);

  a_r5_vec_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend[vec]);

  a_r5_blocked_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && |pend) |-> |act);

  a_r6_ack_enters_service: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> act[$past(vec)]);

  a_r6_ack_grows_active: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq && !ret) |=> $countones(act) == $countones($past(act)) + 1);

  a_r7_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq && !ret) |=> act == $past(act));

  a_r8_ret_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !ack && |act) |=> $countones(act) == $countones($past(act)) - 1);

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_LVL(N_LVL)) chk_i (.*);

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] hw_req = '0, hw_en = '0;
  logic       sw_set = 1'b0;
  logic [2:0] sw_lvl = '0;
  logic       io_cycle = 1'b0, ack = 1'b0, ret = 1'b0;
  logic       irq;
  logic [2:0] vec;
  logic [7:0] pend, act;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .hw_en(hw_en),
    .sw_set(sw_set), .sw_lvl(sw_lvl), .io_cycle(io_cycle),
    .ack(ack), .ret(ret), .irq(irq), .vec(vec), .pend(pend), .act(act)
  );

  // {io, req, en, sw_set, sw_lvl, ack, ret, exp_pend, exp_act, exp_irq, exp_vec}
  localparam int NV = 16;
  localparam logic [42:0] STEPS [NV] = '{
    {1'b0, 8'h05, 8'h04, 1'b0, 3'd0, 1'b0, 1'b0, 8'h04, 8'h00, 1'b1, 3'd2}, // R2 mask blocks lvl0
    {1'b1, 8'hFF, 8'hFF, 1'b1, 3'd7, 1'b0, 1'b0, 8'h04, 8'h00, 1'b1, 3'd2}, // R3 io suspends hw+sw
    {1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b1, 1'b0, 8'h00, 8'h04, 1'b0, 3'd0}, // R6 accept lvl2
    {1'b0, 8'h01, 8'h01, 1'b0, 3'd0, 1'b0, 1'b0, 8'h01, 8'h04, 1'b0, 3'd0}, // R5 lower blocked
    {1'b0, 8'h00, 8'h00, 1'b1, 3'd5, 1'b0, 1'b0, 8'h21, 8'h04, 1'b1, 3'd5}, // R4 sw lvl5
    {1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b1, 1'b0, 8'h01, 8'h24, 1'b0, 3'd0}, // R10 lvl0 stays
    {1'b0, 8'h80, 8'h80, 1'b0, 3'd0, 1'b0, 1'b0, 8'h81, 8'h24, 1'b1, 3'd7}, // R5 nest above 5
    {1'b0, 8'h80, 8'h80, 1'b0, 3'd0, 1'b1, 1'b0, 8'h81, 8'hA4, 1'b0, 3'd7}, // R6 re-raise wins
    {1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 8'h81, 8'h24, 1'b1, 3'd7}, // R8 retire 7
    {1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b1, 1'b1, 8'h01, 8'h84, 1'b0, 3'd0}, // R9 ack+ret
    {1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 8'h01, 8'h04, 1'b0, 3'd0}, // R8
    {1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b1, 1'b0, 8'h01, 8'h04, 1'b0, 3'd0}, // R7 ack ignored
    {1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 8'h01, 8'h00, 1'b1, 3'd0}, // R8 lvl0 freed
    {1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 8'h01, 8'h00, 1'b1, 3'd0}, // R8 empty ret
    {1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b1, 1'b0, 8'h00, 8'h01, 1'b0, 3'd0}, // R6 accept lvl0
    {1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 3'd0}  // R8 all clear
  };

  function automatic string tag_of(input int s);
    case (s)
      0: tag_of = "R2";
      1: tag_of = "R3";
      3, 6: tag_of = "R5";
      4: tag_of = "R4";
      5: tag_of = "R10";
      2, 7, 14: tag_of = "R6";
      9: tag_of = "R9";
      11: tag_of = "R7";
      default: tag_of = "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [7:0] ep, input logic [7:0] ea,
                         input logic ei, input logic [2:0] ev);
    chk(tag, "pend", pend, ep);
    chk(tag, "act", act, ea);
    chk(tag, "irq", {7'd0, irq}, {7'd0, ei});
    chk(tag, "vec", {5'd0, vec}, {5'd0, ev});
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk_all("R1", 8'h00, 8'h00, 1'b0, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int s = 0; s < NV; s++) begin
      logic [42:0] v;
      v = STEPS[s];
      @(negedge clk);
      io_cycle = v[42];
      hw_req   = v[41:34];
      hw_en    = v[33:26];
      sw_set   = v[25];
      sw_lvl   = v[24:22];
      ack      = v[21];
      ret      = v[20];
      @(posedge clk);
      #1;
      chk_all(tag_of(s), v[19:12], v[11:4], v[3], v[2:0]);
    end

    // R1: reset mid-operation clears both bitmaps
    @(negedge clk);
    {io_cycle, ack, ret, sw_set} = '0;
    hw_req = 8'h48; hw_en = 8'hFF;
    @(negedge clk);
    hw_req = 8'h00; ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R1", "act before reset", act, 8'h40);
    #0.5 rst_n = 1'b0;
    #0.5;
    chk_all("R1", 8'h00, 8'h00, 1'b0, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule